// File: doc/BRIEF.md
# Chainable Sampling Converter Serial Port

This block is the digital side of one 16-bit sampling converter that can be wired in a daisy chain. A rising edge on the convert-start input ends acquisition and starts a conversion. The conversion is modelled as a counter of fixed length in system-clock cycles; the analog core is not part of the block. When the count runs out, the block captures the parallel sample word into its output shift register. Its serial data output then shows a high done flag and the block is back in acquisition.

Readout runs while convert-start is low and is paced by falling edges of the serial clock. The first falling edge removes the done flag and puts bit 15 on the output. Each later edge shifts out the next bit and shifts in the chain input from the device upstream. Because of this, the upstream device's result follows this device's bit 0 with no gap, and a host can read N devices through one output with 16·N + 1 falling edges. Convert-start and the serial clock are sampled in the system-clock domain.

Top module: `dsl_chain_port`

## Requirements
- R1: After reset, busy_o and sdo_o are both low.
- R2: A low-to-high change of conv_start_i, as seen in two consecutive system-clock samples, starts a conversion. busy_o is then high for exactly CONV_CYCLES consecutive cycles.
- R3: A running conversion completes with its normal length whatever conv_start_i does. A new rising edge of conv_start_i during a conversion neither restarts nor extends it.
- R4: sdo_o is low for every cycle in which busy_o is high.
- R5: In the cycle busy_o falls, sample_i is captured and sdo_o goes high (the done flag). sdo_o stays high until the first accepted falling edge, and a new conversion replaces an earlier result that was only partly read.
- R6: The first accepted falling edge of sclk_i after a conversion removes the done flag without shifting, so sdo_o shows bit 15. Each later accepted edge moves sdo_o one bit down, from bit 15 to bit 0.
- R7: Each accepted edge after the first shifts chain_i into bit 0. The value chain_i holds at accepted edge k (k ≥ 2) appears on sdo_o after edge k + 15. The upstream bit 15 therefore follows local bit 0 directly.
- R8: A falling edge of sclk_i is ignored while conv_start_i is high or a conversion is running: sdo_o and the stored data are unchanged.
- R9: sclk_i and conv_start_i are sampled on the system clock, and an edge is found by comparing two consecutive samples. Each level must be held for at least two system-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_start_i | input | 1 | Convert start; a rising edge begins a conversion, low enables readout |
| sclk_i | input | 1 | Serial clock; data moves on its falling edges, idles high |
| chain_i | input | 1 | Serial data from the upstream device |
| sample_i | input | DATA_W | Parallel result word captured at the end of a conversion |
| sdo_o | output | 1 | Serial data out: done flag, then result bits, then upstream bits |
| busy_o | output | 1 | High while a conversion is running |

## Verification
The hardest situation to reach is a serial-clock edge or a second convert edge that arrives while a conversion is already counting. The ports give no handshake for this, so the stimulus counts busy cycles from the outside and places toggles of sclk_i and conv_start_i at chosen cycles inside the busy window. It also toggles the serial clock after the conversion has finished while conv_start_i is still held high. After each of these cases a full 32-edge readout of this device and a modelled upstream device shows that no bit was lost or moved. A partial readout that is cut off by a new conversion checks that the new result replaces the old one.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
  typedef enum logic [1:0] {
    SH_EMPTY = 2'd0,  // no result since reset: pass-through
    SH_FLAG  = 2'd1,  // done flag presented
    SH_SHIFT = 2'd2   // shifting result and chain data
  } sh_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dsl_edge_det.sv
module dsl_edge_det #(
  parameter bit IDLE = 1'b0,
  parameter bit FALL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic edge_o
);
  logic smp_q, prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= IDLE;
      prv_q <= IDLE;
    end else begin
      smp_q <= d_i;
      prv_q <= smp_q;
    end
  end

  assign lvl_o = smp_q;

  generate
    if (FALL) begin : g_fall
      assign edge_o = prv_q & ~smp_q;
    end else begin : g_rise
      assign edge_o = smp_q & ~prv_q;
    end
  endgenerate
endmodule

// File: rtl/dsl_conv_timer.sv
module dsl_conv_timer #(
  parameter int unsigned CONV_CYCLES = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = dsl_pkg::cnt_width(CONV_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= LAST;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q);
  a_r2_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
  a_r3_start_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));
  a_r3_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dsl_out_shift.sv
module dsl_out_shift #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              shift_i,
  input  logic              chain_i,
  input  logic              busy_i,
  output logic              sdo_o
);
  import dsl_pkg::*;

  sh_state_e         st_q;
  logic [DATA_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SH_EMPTY;
      sreg_q <= '0;
    end else if (load_i) begin
      st_q   <= SH_FLAG;
      sreg_q <= sample_i;
    end else if (shift_i) begin
      if (st_q == SH_FLAG) begin
        st_q <= SH_SHIFT;  // first edge only drops the flag
      end else begin
        sreg_q <= {sreg_q[DATA_W-2:0], chain_i};
      end
    end
  end

  always_comb begin
    if (busy_i)              sdo_o = 1'b0;
    else if (st_q == SH_FLAG) sdo_o = 1'b1;
    else                     sdo_o = sreg_q[DATA_W-1];
  end

  a_r5_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (st_q == SH_FLAG) && (sreg_q == $past(sample_i)));
  a_r6_first_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SH_FLAG && shift_i && !load_i) |=> $stable(sreg_q));
  a_r7_chain_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SH_SHIFT && shift_i && !load_i) |=> (sreg_q[0] == $past(chain_i)));
endmodule

// File: rtl/dsl_chain_port.sv
module dsl_chain_port #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_start_i,
  input  logic              sclk_i,
  input  logic              chain_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              busy_o
);
  logic cnv_lvl, cnv_rise, sclk_lvl, sclk_fall;
  logic conv_done, shift_en;

  dsl_edge_det #(.IDLE(1'b0), .FALL(1'b0)) u_cnv_det (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(conv_start_i),
    .lvl_o (cnv_lvl), .edge_o(cnv_rise)
  );

  dsl_edge_det #(.IDLE(1'b1), .FALL(1'b1)) u_sclk_det (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sclk_i),
    .lvl_o (sclk_lvl), .edge_o(sclk_fall)
  );

  dsl_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk_i  (clk_i), .rst_ni(rst_ni), .start_i(cnv_rise),
    .busy_o (busy_o), .done_o(conv_done)
  );

  // readout only with convert low and no conversion in flight
  assign shift_en = sclk_fall && !cnv_lvl && !busy_o;

  dsl_out_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i   (clk_i), .rst_ni(rst_ni), .load_i(conv_done),
    .sample_i(sample_i), .shift_i(shift_en), .chain_i(chain_i),
    .busy_i  (busy_o), .sdo_o(sdo_o)
  );

  a_r8_ignore_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_fall && cnv_lvl && !busy_o) |=> $stable(sdo_o));
  a_r9_fall_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_fall |-> (!sclk_lvl && $past(sclk_lvl)));
  a_r4_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !sdo_o);
endmodule

// File: tb/dsl_chain_port_bench.sv
module dsl_chain_port_bench;
  localparam int unsigned DW = 16;
  localparam int unsigned NC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0, sclk = 1'b1, chain = 1'b0;
  logic [DW-1:0] smp = '0;
  logic sdo, busy;
  int n_chk = 0, n_fail = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  dsl_chain_port #(.DATA_W(DW), .CONV_CYCLES(NC)) u_dsl_chain_port (
    .clk_i(clk), .rst_ni(rst_n), .conv_start_i(cnv), .sclk_i(sclk),
    .chain_i(chain), .sample_i(smp), .sdo_o(sdo), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // mode 0: short pulse; 1: convert held high with sclk toggles; 2: extra pulse and toggles during busy
  task automatic convert(input int mode);
    int len = 0;
    cnv = 1'b1;
    wclk(2);
    if (mode != 1) cnv = 1'b0;
    for (int w = 0; w < 10 && !busy; w++) wclk(1);
    while (busy && len < 1000) begin
      chk(sdo == 1'b0, "R4", sdo, 0);
      if (mode == 1 && len == 3) sclk = 1'b0;
      if (mode == 1 && len == 6) sclk = 1'b1;
      if (mode == 2 && len == 4) cnv = 1'b1;
      if (mode == 2 && len == 7) cnv = 1'b0;
      if (mode == 2 && len == 9) sclk = 1'b0;
      if (mode == 2 && len == 12) sclk = 1'b1;
      len++;
      wclk(1);
    end
    chk(len == NC, (mode == 0) ? "R2" : "R3", len, NC);
    chk(sdo == 1'b1, "R5", sdo, 1);
    if (mode == 1) begin
      sclk = 1'b0; wclk(3); sclk = 1'b1; wclk(3);
      chk(sdo == 1'b1, "R8", sdo, 1);
      cnv = 1'b0;
      wclk(3);
    end
    if (mode != 0) chk(sdo == 1'b1, "R8", sdo, 1);
  endtask

  task automatic fall_edge(input logic din);
    chain = din;
    sclk = 1'b0; wclk(3);
    sclk = 1'b1; wclk(3);
  endtask

  task automatic readout(input logic [DW-1:0] d, input logic [DW-1:0] u);
    logic exp;
    logic din;
    for (int k = 1; k <= 2 * DW; k++) begin
      if (k == 1) din = 1'b1;
      else if (k <= DW + 1) din = u[DW + 1 - k];
      else din = 1'b0;
      fall_edge(din);
      exp = (k <= DW) ? d[DW - k] : u[2 * DW - k];
      chk(sdo == exp, (k <= DW) ? "R6" : "R7", sdo, exp);
    end
  endtask

  initial begin
    logic [DW-1:0] d, u;
    wclk(3);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(sdo == 1'b0, "R1", sdo, 0);
    rst_n = 1'b1;
    wclk(3);
    chk(busy == 1'b0 && sdo == 1'b0, "R1", {busy, sdo}, 0);
    // R9: a one-cycle convert glitch below the two-sample rule still shows as a rise; hold levels >= 2 cycles
    for (int p = 0; p < 12; p++) begin
      if (p == 0) begin d = 16'h0000; u = 16'hFFFF; end
      else if (p == 1) begin d = 16'hFFFF; u = 16'h0000; end
      else begin
        d = DW'((p * 16'h3B1D) ^ 16'hA5C3);
        u = DW'((p * 16'h7F4B) ^ 16'h5A18);
      end
      smp = d;
      convert(p % 3);
      smp = ~d;  // capture must have happened already (R5)
      readout(d, u);
    end
    // R5: partial readout overwritten by new conversion
    smp = 16'h8001;
    convert(0);
    fall_edge(1'b1); fall_edge(1'b0); fall_edge(1'b1);
    chk(sdo == 1'b0, "R6", sdo, 0);
    smp = 16'h4C2E;
    convert(0);
    readout(16'h4C2E, 16'h9137);
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done_flag) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule